// File: doc/BRIEF.md
# I2C Serial Clock Timebase

This block derives the serial-clock timing of an I2C master from a fast system clock. Two programmable counters run in cascade. The first divides the system clock by (A+1). The second advances only when the first wraps, and it divides by a further (B+1). The output of the second counter is a one-cycle pulse, the bit-timing quantum. A phase counter gathers 22 quanta into one serial-clock period. It drives a phase output that is high for 11 quanta and low for 11 quanta, so the serial clock runs at the system clock divided by 22 × (A+1) × (B+1).

Both divider values come from one control word: A from bits [15:14] and B from bits [13:8]. The block captures them only while it is disabled. The bus controller that drives the enable therefore changes the bus rate only between transfers. When the enable is dropped, every counter restarts and the phase output is held high, which is the idle level of the bus clock.

Top module: `i2c_scl_timebase`

## Requirements
- R1: With dividers A and B active, `quantum_tick` is a one-cycle pulse that repeats every (A+1)×(B+1) clock cycles. Counting the first cycle in which `enable` is high as cycle 0, the first pulse falls on cycle (A+1)×(B+1)−1.
- R2: Divider A is read from `ctrl_word[15:14]` (0..3) and divider B from `ctrl_word[13:8]` (0..63). Bits [7:0] have no effect on timing.
- R3: `scl_phase` starts high when enabled. It goes low in the cycle after the 11th quantum pulse and high again in the cycle after the 22nd, and then repeats. This gives a period of 22 quanta with a 50% duty cycle.
- R4: With A=0 and B=0, `quantum_tick` is high in every enabled cycle and the `scl_phase` period is 22 clock cycles, the fastest rate the block can produce.
- R5: The divider values are captured only while `enable` is low. A change to `ctrl_word` while `enable` is high has no effect until `enable` has been low for at least one cycle.
- R6: While `enable` is low, `quantum_tick` is 0, and `scl_phase` is 1 from the cycle after the first low sample. Re-enabling restarts the timing from cycle 0 as in R1.
- R7: Synchronous reset (`rst` high) drives `scl_phase` to 1 and clears both captured dividers to 0. Enabling straight out of reset, without a disabled cycle, therefore gives a pulse on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the timebase; low restarts it and captures the dividers |
| ctrl_word | input | 16 | Control word carrying divider A [15:14] and divider B [13:8] |
| quantum_tick | output | 1 | One-cycle pulse per bit-timing quantum |
| scl_phase | output | 1 | Serial-clock phase, high or low for 11 quanta each |

## Verification
On every cycle, the assertions check the following: the spacing of quantum pulses against the captured dividers, that the second stage moves only on a carry from the first, that the phase output changes only on a pulse, the range of the phase counter, that the dividers are frozen while enabled, and the idle and reset levels. Only the bench's scenarios show the rest. These are that the dividers come from the right bit positions and that the low bits are ignored, that a mid-transfer control change is deferred, the exact cycle of the first pulse after enabling, the full 22-quantum serial-clock waveform, and the behaviour when enabling straight out of reset.

// File: rtl/scl_timebase_pkg.sv
package scl_timebase_pkg;
  localparam int CTRL_W_DEF = 16;
  localparam int A_LSB_DEF  = 14;
  localparam int A_W_DEF    = 2;
  localparam int B_LSB_DEF  = 8;
  localparam int B_W_DEF    = 6;
  localparam int QUANTA_DEF = 22;

  // clock cycles in one bit-timing quantum for given divider codes
  function automatic int quantum_len(input int a_code, input int b_code);
    return (a_code + 1) * (b_code + 1);
  endfunction

  // clock cycles in one full serial-clock period
  function automatic int scl_period(input int a_code, input int b_code, input int quanta);
    return quanta * quantum_len(a_code, b_code);
  endfunction
endpackage

// File: rtl/scl_down_stage.sv
module scl_down_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         advance,
  input  logic [W-1:0] reload_val,
  output logic         wrap,
  output logic [W-1:0] count
);
  assign wrap = advance && (count == '0);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (restart)
      count <= reload_val;
    else if (advance)
      count <= wrap ? reload_val : count - W'(1);
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int QUANTA = 22,
  localparam int HALF = QUANTA / 2,
  localparam int PW = $clog2(QUANTA)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  output logic          scl,
  output logic          toggle,
  output logic [PW-1:0] phase_cnt
);
  logic at_end;
  assign at_end = (phase_cnt == PW'(QUANTA - 1));
  assign toggle = tick && (at_end || phase_cnt == PW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase_cnt <= '0;
      scl       <= 1'b1;
    end else if (tick) begin
      phase_cnt <= at_end ? '0 : phase_cnt + PW'(1);
      if (toggle) scl <= ~scl;
    end
  end
endmodule

// File: rtl/i2c_scl_timebase.sv
module i2c_scl_timebase
  import scl_timebase_pkg::*;
#(
  parameter int CTRL_W = CTRL_W_DEF,
  parameter int A_LSB  = A_LSB_DEF,
  parameter int A_W    = A_W_DEF,
  parameter int B_LSB  = B_LSB_DEF,
  parameter int B_W    = B_W_DEF,
  parameter int QUANTA = QUANTA_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              quantum_tick,
  output logic              scl_phase
);
  localparam int PW = $clog2(QUANTA);

  logic [A_W-1:0] fld_a, div_a_q, reload_a, cnt_a;
  logic [B_W-1:0] fld_b, div_b_q, reload_b, cnt_b;
  logic           carry_a, carry_b, scl_toggle;
  logic [PW-1:0]  phase_cnt;

  assign fld_a = ctrl_word[A_LSB +: A_W];
  assign fld_b = ctrl_word[B_LSB +: B_W];

  // dividers are captured only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      div_a_q <= '0;
      div_b_q <= '0;
    end else if (!enable) begin
      div_a_q <= fld_a;
      div_b_q <= fld_b;
    end
  end

  assign reload_a = enable ? div_a_q : fld_a;
  assign reload_b = enable ? div_b_q : fld_b;

  scl_down_stage #(.W(A_W)) u_stage_a (
    .clk(clk), .rst(rst), .restart(!enable), .advance(enable),
    .reload_val(reload_a), .wrap(carry_a), .count(cnt_a)
  );

  scl_down_stage #(.W(B_W)) u_stage_b (
    .clk(clk), .rst(rst), .restart(!enable), .advance(carry_a),
    .reload_val(reload_b), .wrap(carry_b), .count(cnt_b)
  );

  assign quantum_tick = carry_b;

  scl_phase_gen #(.QUANTA(QUANTA)) u_phase (
    .clk(clk), .rst(rst), .clear(!enable), .tick(carry_b),
    .scl(scl_phase), .toggle(scl_toggle), .phase_cnt(phase_cnt)
  );
endmodule

// File: rtl/scl_timebase_chk.sv
module scl_timebase_chk
  import scl_timebase_pkg::*;
#(
  parameter int A_W = 2,
  parameter int B_W = 6,
  parameter int PW = 5,
  parameter int QUANTA = 22
) (
  input logic           clk,
  input logic           rst,
  input logic           enable,
  input logic           quantum_tick,
  input logic           scl_phase,
  input logic           carry_a,
  input logic [B_W-1:0] cnt_b,
  input logic [A_W-1:0] div_a_q,
  input logic [B_W-1:0] div_b_q,
  input logic [PW-1:0]  phase_cnt
);
  logic [31:0] gap_cnt;
  int          exp_len;
  assign exp_len = quantum_len(int'(div_a_q), int'(div_b_q));

  always_ff @(posedge clk) begin
    if (rst || !enable || quantum_tick) gap_cnt <= '0;
    else gap_cnt <= gap_cnt + 32'd1;
  end

  // R1: pulses fall exactly at quantum boundaries
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    enable |-> (quantum_tick == (int'(gap_cnt) == exp_len - 1)));
  a_r1_tick_needs_carry: assert property (@(posedge clk) disable iff (rst)
    quantum_tick |-> carry_a);
  a_r1_b_moves_on_carry: assert property (@(posedge clk) disable iff (rst)
    (enable && !carry_a) |=> $stable(cnt_b));
  // R3: phase changes only on a quantum pulse; counter stays in range
  a_r3_scl_on_tick_only: assert property (@(posedge clk) disable iff (rst)
    (enable && !quantum_tick) |=> $stable(scl_phase));
  a_r3_phase_range: assert property (@(posedge clk) disable iff (rst)
    int'(phase_cnt) < QUANTA);
  // R5: dividers frozen while running
  a_r5_div_frozen: assert property (@(posedge clk) disable iff (rst)
    enable |=> ($stable(div_a_q) && $stable(div_b_q)));
  // R6: idle behaviour
  a_r6_idle_no_tick: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !quantum_tick);
  a_r6_idle_scl_high: assert property (@(posedge clk) disable iff (rst)
    !enable |=> scl_phase);
  // R7: reset levels
  a_r7_reset_state: assert property (@(posedge clk)
    rst |=> (scl_phase && div_a_q == '0 && div_b_q == '0));
endmodule

bind i2c_scl_timebase scl_timebase_chk #(
  .A_W(A_W), .B_W(B_W), .PW(PW), .QUANTA(QUANTA)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .quantum_tick(quantum_tick),
  .scl_phase(scl_phase), .carry_a(carry_a), .cnt_b(cnt_b),
  .div_a_q(div_a_q), .div_b_q(div_b_q), .phase_cnt(phase_cnt)
);

// File: tb/tb_i2c_scl_timebase.sv
`timescale 1ns/1ps
module tb_i2c_scl_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] ctrl_word = 16'h0000;
  logic        quantum_tick, scl_phase;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_scl_timebase dut (
    .clk(clk), .rst(rst), .enable(enable), .ctrl_word(ctrl_word),
    .quantum_tick(quantum_tick), .scl_phase(scl_phase)
  );

  localparam int NV = 7;
  // control word (with junk in bits 7:0) and expected quantum length in cycles
  localparam logic [15:0] VEC_CTRL [NV] = '{16'h005A, 16'h403C, 16'h01FF,
                                            16'hC500, 16'h8981, 16'hFF00, 16'h3F33};
  localparam int VEC_Q [NV] = '{1, 2, 2, 24, 30, 256, 64};

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // run an enabled window and compare every cycle against a cycle model
  task automatic run_window(input logic [15:0] ctrl, input int q, input int ncyc,
                            input bit change_mid, input string req);
    int tick_bad = 0;
    int scl_bad = 0;
    int ticks = 0;
    int first_tick = -1;
    @(negedge clk);
    enable = 1'b0;
    ctrl_word = ctrl;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      if (change_mid && i == 5 * q) ctrl_word = 16'h4100;
      #1;
      if (quantum_tick !== (((i + 1) % q) == 0)) tick_bad++;
      if (scl_phase !== ((ticks % 22) < 11)) scl_bad++;
      if (quantum_tick === 1'b1) begin
        if (first_tick < 0) first_tick = i;
        ticks++;
      end
      @(negedge clk);
    end
    check(req, "tick pattern mismatches", tick_bad, 0);
    check("R3", "scl pattern mismatches", scl_bad, 0);
    check("R1", "first tick cycle", first_tick, q - 1);
  endtask

  initial begin
    int hits;
    // R7: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R7", "scl in reset", int'(scl_phase), 1);
    check("R7", "tick in reset (disabled)", int'(quantum_tick), 0);

    // R7: enabling straight out of reset uses cleared dividers
    @(negedge clk);
    ctrl_word = 16'hFF00;
    enable = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hits = 0;
    for (int i = 0; i < 4; i++) begin
      #1;
      if (quantum_tick === 1'b1) hits++;
      @(negedge clk);
    end
    check("R7", "ticks in 4 cycles after reset", hits, 4);

    // table of vectors: R1, R2 (low bits junk), R3, R4 (first vector), R5 (mid change)
    for (int v = 0; v < NV; v++) begin
      run_window(VEC_CTRL[v], VEC_Q[v], 44 * VEC_Q[v], (v >= 3),
                 (v == 0) ? "R4" : ((v >= 3) ? "R5" : "R2"));
    end

    // R6: disable mid low phase at fastest rate
    run_window(16'h0000, 1, 15, 1'b0, "R4");
    enable = 1'b0;
    #1;
    check("R6", "tick right after disable", int'(quantum_tick), 0);
    @(negedge clk);
    #1;
    check("R6", "scl one cycle after disable", int'(scl_phase), 1);
    hits = 0;
    ctrl_word = 16'h0000;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      #1;
      if (quantum_tick !== 1'b0 || scl_phase !== 1'b1) hits++;
    end
    check("R6", "idle cycles with activity", hits, 0);

    // R6: restart after partial count, then R5 deferred change takes effect
    run_window(16'h4000, 2, 88, 1'b0, "R6");
    run_window(16'h4100, 4, 88, 1'b0, "R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule